// File: doc/BRIEF.md
# Opcode length and cycle timer

This block takes one CPU opcode byte from the add-with-carry and shift-left families. For each opcode it reports how many bytes the instruction takes in memory and how many clock cycles it runs. For indexed reads the cycle count depends on the operand address. When the base address plus the zero-extended index register lands in a different 256-byte page than the base, the read costs one more cycle. The indexed shift is a read-modify-write, so it always costs its full fixed count and never takes that extra cycle.

The caller sets the opcode, base address and index and pulses `start_i`. On that clock edge the block latches the decoded results. It then counts the final number of cycles with `busy_o` high and raises `done_o` in the last of those cycles. The caller supplies the base address. For the indirect-post-indexed form this is the pointer already read from zero page. Opcodes outside the supported set are flagged illegal and are timed with a default length and count.

Top module: `olt_timer`

## Requirements
- R1: Add-with-carry opcodes decode to (length, base cycles) as follows: 0x69 (2,2), 0x65 (2,3), 0x75 (2,4), 0x6D (3,4), 0x7D (3,4), 0x79 (3,4), 0x61 (2,6), 0x71 (2,5). `len_o` is the byte count in binary.
- R2: Shift-left opcodes decode as follows: 0x0A (1,2), 0x06 (2,5), 0x16 (2,6), 0x0E (3,6), 0x1E (3,7).
- R3: `page_cross_o` is 1 only for opcodes 0x7D, 0x79 and 0x71. For these it is 1 when bits 15:8 of the 16-bit truncated sum base + zero-extended index differ from bits 15:8 of base.
- R4: `cycles_o` is the base cycle count plus 1 when `page_cross_o` is 1. For 0x1E the count is 7 whatever the addresses are.
- R5: Any other opcode gives `illegal_o`=1, `len_o`=1, `cycles_o`=2 and `page_cross_o`=0. Every supported opcode gives `illegal_o`=0.
- R6: A `start_i` sampled high at a clock edge while `busy_o` is low updates all result outputs at that edge. `busy_o` is then high for exactly `cycles_o` cycles.
- R7: `done_o` is high for exactly one cycle, the last cycle in which `busy_o` is high, and never while `busy_o` is low.
- R8: A `start_i` sampled while `busy_o` is high is ignored. No output changes because of it, and the running count finishes unchanged.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| opcode_i | input | 8 | Opcode byte |
| base_addr_i | input | 16 | Base operand address (pointer for post-indexed form) |
| index_i | input | 8 | Index register value |
| len_o | output | 2 | Instruction length in bytes |
| cycles_o | output | 4 | Final cycle count |
| page_cross_o | output | 1 | Indexed read crossed a page |
| illegal_o | output | 1 | Opcode not supported |
| busy_o | output | 1 | Countdown running |
| done_o | output | 1 | Last cycle of the countdown |

## Verification
Some behaviours are checked by assertions on every cycle. These are the illegal-opcode defaults, the page-cross flag appearing only with a matching one-cycle increase, the absence of a penalty on the indexed shift, done being confined to the last busy cycle, and results holding steady across starts that arrive while busy. The exact table values, the boundary of the page rule (offsets 0xFF, 0x00 and wrap at 0xFFFF) and the precise busy duration for each count can only be shown by the bench's scenarios. These are compared each clock against a behavioural model.

// File: rtl/olt_pkg.sv
package olt_pkg;
  localparam int unsigned LEN_W = 2;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [3:0] {
    MODE_ACC, MODE_IMM, MODE_ZP, MODE_ZPX, MODE_ABS, MODE_ABSX,
    MODE_ABSY, MODE_INDX, MODE_INDY, MODE_NONE
  } addr_mode_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] base_cyc;
    logic             idx_read;  // eligible for page penalty
    logic             illegal;
    addr_mode_e       mode;
  } dec_t;
endpackage

// File: rtl/olt_decode.sv
module olt_decode
  import olt_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(1);
  localparam logic [CNT_W-1:0] DEF_CYC = CNT_W'(2);

  logic [3:0] row, col;
  assign row = opcode_i[7:4];
  assign col = opcode_i[3:0];

  always_comb begin
    dec_o = '{len: DEF_LEN, base_cyc: DEF_CYC, idx_read: 1'b0,
              illegal: 1'b1, mode: MODE_NONE};
    unique case ({row, col})
      // add with carry
      8'h69: dec_o = '{2'd2, 4'd2, 1'b0, 1'b0, MODE_IMM};
      8'h65: dec_o = '{2'd2, 4'd3, 1'b0, 1'b0, MODE_ZP};
      8'h75: dec_o = '{2'd2, 4'd4, 1'b0, 1'b0, MODE_ZPX};
      8'h6D: dec_o = '{2'd3, 4'd4, 1'b0, 1'b0, MODE_ABS};
      8'h7D: dec_o = '{2'd3, 4'd4, 1'b1, 1'b0, MODE_ABSX};
      8'h79: dec_o = '{2'd3, 4'd4, 1'b1, 1'b0, MODE_ABSY};
      8'h61: dec_o = '{2'd2, 4'd6, 1'b0, 1'b0, MODE_INDX};
      8'h71: dec_o = '{2'd2, 4'd5, 1'b1, 1'b0, MODE_INDY};
      // shift left; indexed form is RMW, no penalty
      8'h0A: dec_o = '{2'd1, 4'd2, 1'b0, 1'b0, MODE_ACC};
      8'h06: dec_o = '{2'd2, 4'd5, 1'b0, 1'b0, MODE_ZP};
      8'h16: dec_o = '{2'd2, 4'd6, 1'b0, 1'b0, MODE_ZPX};
      8'h0E: dec_o = '{2'd3, 4'd6, 1'b0, 1'b0, MODE_ABS};
      8'h1E: dec_o = '{2'd3, 4'd7, 1'b0, 1'b0, MODE_ABSX};
      default: ;
    endcase
  end
endmodule

// File: rtl/olt_page_cross.sv
module olt_page_cross #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PAGE_BITS = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              cross_o
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W;
  logic [ADDR_W-1:0] sum;
  assign sum     = base_i + {{PAD_W{1'b0}}, idx_i};
  assign cross_o = sum[ADDR_W-1:PAGE_BITS] != base_i[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/olt_countdown.sv
module olt_countdown #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      cnt_q  <= load_val_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R6
  AST_LOAD_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && load_val_i != '0) |=> busy_o); // R6
endmodule

// File: rtl/olt_timer.sv
module olt_timer
  import olt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic              page_cross_o,
  output logic              illegal_o,
  output logic              busy_o,
  output logic              done_o
);
  dec_t             dec;
  logic             crossed, penalty, accept;
  logic [CNT_W-1:0] final_cyc;

  olt_decode i_decode (.opcode_i(opcode_i), .dec_o(dec));

  olt_page_cross #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_BITS(8)) i_page (
    .base_i (base_addr_i),
    .idx_i  (index_i),
    .cross_o(crossed)
  );

  assign penalty   = dec.idx_read && crossed;
  assign final_cyc = dec.base_cyc + CNT_W'(penalty);
  assign accept    = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o        <= '0;
      cycles_o     <= '0;
      page_cross_o <= 1'b0;
      illegal_o    <= 1'b0;
    end else if (accept) begin
      len_o        <= dec.len;
      cycles_o     <= final_cyc;
      page_cross_o <= penalty;
      illegal_o    <= dec.illegal;
    end
  end

  olt_countdown #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(final_cyc),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  AST_ILLEGAL_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (len_o == 2'd1 && cycles_o == 4'd2 && !page_cross_o)); // R5
  AST_PX_ADDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && crossed && opcode_i == 8'h79) |=> (page_cross_o && cycles_o == 4'd5)); // R4
  AST_SHIFT_NO_PENALTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && opcode_i == 8'h1E) |=> (!page_cross_o && cycles_o == 4'd7)); // R4
  AST_PX_ONLY_INDEXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_cross_o |-> (cycles_o == 4'd5 || cycles_o == 4'd6) && len_o != 2'd1); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cycles_o) && $stable(len_o) && $stable(illegal_o))); // R8
endmodule

// File: tb/test_olt_timer.sv
module test_olt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op = 8'h00;
  logic [15:0] base = 16'h0000;
  logic [7:0]  idx = 8'h00;
  logic [1:0]  len;
  logic [3:0]  cyc;
  logic        px, ill, busy, done;

  int checks = 0;
  int errors = 0;
  int cycle_cnt = 0;
  bit finished = 1'b0;
  bit compare_en = 1'b0;

  // model state
  int  m_len = 0, m_cyc = 0, m_cnt = 0;
  bit  m_px = 0, m_ill = 0, m_busy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  olt_timer i_olt_timer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(op),
    .base_addr_i(base), .index_i(idx), .len_o(len), .cycles_o(cyc),
    .page_cross_o(px), .illegal_o(ill), .busy_o(busy), .done_o(done)
  );

  function automatic void ref_timing(input logic [7:0] o, input logic [15:0] b,
                                     input logic [7:0] x, output int l, output int c,
                                     output bit p, output bit il);
    int sum;
    bit pen;
    sum = (int'(b) + int'(x)) % 65536;
    pen = (sum / 256) != (int'(b) / 256);
    il = 0; p = 0;
    case (o)
      8'h69: begin l = 2; c = 2; end
      8'h65: begin l = 2; c = 3; end
      8'h75: begin l = 2; c = 4; end
      8'h6D: begin l = 3; c = 4; end
      8'h7D, 8'h79: begin l = 3; c = 4; p = pen; end
      8'h61: begin l = 2; c = 6; end
      8'h71: begin l = 2; c = 5; p = pen; end
      8'h0A: begin l = 1; c = 2; end
      8'h06: begin l = 2; c = 5; end
      8'h16: begin l = 2; c = 6; end
      8'h0E: begin l = 3; c = 6; end
      8'h1E: begin l = 3; c = 7; end
      default: begin l = 1; c = 2; il = 1; end
    endcase
    if (p) c = c + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len = 0; m_cyc = 0; m_cnt = 0; m_px = 0; m_ill = 0; m_busy = 0;
    end else if (start && !m_busy) begin
      ref_timing(op, base, idx, m_len, m_cyc, m_px, m_ill);
      m_cnt = m_cyc; m_busy = 1;
    end else if (m_busy) begin
      if (m_cnt == 1) m_busy = 0;
      m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycle_cnt, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_en && !finished) begin
      chk("R1/R2 len", int'(len), m_len);
      chk("R4 cycles", int'(cyc), m_cyc);
      chk("R3 page_cross", int'(px), int'(m_px));
      chk("R5 illegal", int'(ill), int'(m_ill));
      chk("R6 busy", int'(busy), int'(m_busy));
      chk("R7 done", int'(done), int'(m_busy && m_cnt == 1));
    end
  end

  always @(posedge clk) begin
    cycle_cnt++;
    if (cycle_cnt > WATCHDOG && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input logic [7:0] o, input logic [15:0] b, input logic [7:0] x);
    @(posedge clk); #2;
    start = 1; op = o; base = b; idx = x;
    @(posedge clk); #2;
    start = 0;
    while (m_busy) @(posedge clk);
    #2;
  endtask

  initial begin
    int busy_len;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9 len", int'(len), 0);
    chk("R9 cycles", int'(cyc), 0);
    chk("R9 busy/done", int'(busy | done | px | ill), 0);
    rst_n = 1;
    compare_en = 1;
    // R1 table, no crossing
    run(8'h69, 16'h0200, 8'h00);
    run(8'h65, 16'h0010, 8'h05);
    run(8'h75, 16'h00F0, 8'h20);
    run(8'h6D, 16'h12FF, 8'h10);
    run(8'h7D, 16'h1200, 8'h10);
    run(8'h79, 16'h3400, 8'hFF);
    run(8'h61, 16'h0080, 8'h90);
    run(8'h71, 16'h4410, 8'h20);
    // R3/R4 crossing boundaries
    run(8'h7D, 16'h12FF, 8'h01);
    run(8'h79, 16'h3401, 8'hFF);
    run(8'h71, 16'hFFF0, 8'h20);
    run(8'h79, 16'h34FF, 8'h00);
    // R2 table; 1E never penalised
    run(8'h0A, 16'h0000, 8'h00);
    run(8'h06, 16'h0040, 8'h00);
    run(8'h16, 16'h00FF, 8'h01);
    run(8'h0E, 16'hABCD, 8'h00);
    run(8'h1E, 16'h12FF, 8'hFF);
    chk("R4 no penalty on 0x1E", int'(cyc), 7);
    // R5 illegal opcodes, with crossing addresses
    run(8'h00, 16'h12FF, 8'h01);
    run(8'hEA, 16'h0000, 8'h00);
    run(8'h7E, 16'h12FF, 8'h80);
    chk("R5 illegal flag", int'(ill), 1);
    // R8 start while busy ignored
    @(posedge clk); #2;
    start = 1; op = 8'h61; base = 16'h0000; idx = 8'h00;
    @(posedge clk); #2;
    op = 8'h0A;
    repeat (3) @(posedge clk);
    #2;
    start = 0;
    busy_len = 0;
    while (busy) begin
      busy_len++;
      @(posedge clk); #2;
    end
    chk("R8 count kept", int'(cyc), 6);
    chk("R8 len kept", int'(len), 2);
    // R6 duration measured at ports
    @(posedge clk); #2;
    start = 1; op = 8'h1E; base = 16'h0000; idx = 8'h00;
    @(posedge clk); #2;
    start = 0;
    busy_len = 0;
    while (busy) begin
      busy_len++;
      @(posedge clk); #2;
    end
    chk("R6 busy duration", busy_len, 7);
    // back to back: start held across done
    @(posedge clk); #2;
    start = 1; op = 8'h69;
    repeat (6) @(posedge clk);
    #2;
    start = 0;
    while (m_busy) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule